// File: doc/BRIEF.md
# Real-Time Clock Core with Alarm

This block keeps the time of day in a real-time clock. It holds a day count plus hour, minute and second counters. An external strobe advances the counters by one second per pulse while the clock is running. Software reaches every register over a small word-wide bus: an address, a write enable, write data, and read data that is returned combinationally for the address presented. Each time field can be written directly. A write replaces the field on the same clock edge.

A second set of registers holds an alarm time. The core compares the running time against it after every one-second step. When the counters step into the alarm time, an alarm event is latched. Every step also latches a per-second update event. Both events sit in a status register that software clears by writing ones. A separate enable register decides which latched events drive the single interrupt line.

There is no calendar. Time is the day count times 86400, plus hours times 3600, plus minutes times 60, plus seconds. The day count simply wraps at its own width.

Top module: `rtc_alarm_core`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq` is 0.
- R2: Word addresses are: 0 time hour/minute, 1 time seconds, 2 time day, 3 alarm hour/minute, 4 alarm seconds, 5 alarm day, 6 control, 7 status, 8 interrupt enable. Any other address reads 0. In both hour/minute registers, hours sit in bits 12:8 and minutes in bits 5:0. Seconds sit in bits 5:0. The day sits in bits DAY_W-1:0. Bits outside these fields read 0.
- R3: On each step, seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day count.
- R4: The day count wraps from 2^DAY_W-1 to 0. With the default of 9 bits, day 511 at 23:59:59 steps to day 0 at 00:00:00.
- R5: Control bit 7 is the run bit, and it reads back as written. The other control bits read 0. While the run bit is 0, strobes leave the time unchanged.
- R6: A bus write to any time register takes effect on that clock edge. If a strobe arrives on the same edge, the write wins and no step happens.
- R7: Status bit 2 (alarm) sets when a step makes day, hour, minute and second all equal the alarm registers. Writing the time registers to the alarm value does not set it.
- R8: Status bit 4 (update) sets after every step.
- R9: Status bits stay set until a 1 is written to them. Writing 0 has no effect. If an event and a clear land on the same edge, the event wins.
- R10: `irq` is 1 exactly when some status bit is 1 and its enable bit is 1. Only enable bits 2 and 4 exist; the other enable bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_strobe | input | 1 | One-cycle pulse once per second |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `sec_strobe` is a pulse at most one cycle wide. They also assume that software loads only legal values into the time fields: hours below 24, and minutes and seconds below 60. The range and wrap properties depend on that. The stimulus keeps every written value inside those ranges and always returns the strobe low after a single cycle. It also spaces strobes at least two cycles apart, so each latched event can be observed before the next step.

// File: rtl/rtc_alarm_pkg.sv
// Package rtc_alarm_pkg
// Holds the shared constants and types of the real-time clock core:
// the register word addresses, the status and enable bit positions,
// the field layout of the packed hour/minute word and the packed
// time-of-day type. Assumes word addressing on the register bus.
package rtc_alarm_pkg;

    // Register word addresses
    localparam int unsigned ADR_TIME_HM  = 0;
    localparam int unsigned ADR_TIME_SEC = 1;
    localparam int unsigned ADR_TIME_DAY = 2;
    localparam int unsigned ADR_ALM_HM   = 3;
    localparam int unsigned ADR_ALM_SEC  = 4;
    localparam int unsigned ADR_ALM_DAY  = 5;
    localparam int unsigned ADR_CTRL     = 6;
    localparam int unsigned ADR_STATUS   = 7;
    localparam int unsigned ADR_IRQ_EN   = 8;

    // Field widths and positions
    localparam int unsigned HR_W    = 5;
    localparam int unsigned MN_W    = 6;
    localparam int unsigned SC_W    = 6;
    localparam int unsigned HR_LSB  = 8;
    localparam int unsigned MN_LSB  = 0;
    localparam int unsigned RUN_BIT = 7;

    // Event sources: index 0 is the alarm, index 1 is the per-second update
    localparam int unsigned NUM_EVT = 2;
    localparam int unsigned EVT_ALARM = 0;
    localparam int unsigned EVT_UPD   = 1;
    localparam int unsigned BIT_ALARM = 2;
    localparam int unsigned BIT_UPD   = 4;

    // Wrap limits
    localparam int unsigned SC_LAST = 59;
    localparam int unsigned MN_LAST = 59;
    localparam int unsigned HR_LAST = 23;

    typedef struct packed {
        logic [HR_W-1:0] hr;
        logic [MN_W-1:0] mn;
        logic [SC_W-1:0] sc;
    } hms_t;

endpackage

// File: rtl/rtc_time_chain.sv
// Module rtc_time_chain
// Holds the running seconds, minutes, hours and day counters and the
// carry chain between them. A strobe advances the chain by one second
// when run is high and no time field is being written that cycle.
// step_q pulses for one cycle after each applied step.
// Assumes: the strobe is at most one cycle wide; written values are in range.
module rtc_time_chain
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             strobe,
    input  logic             wr_hm,
    input  logic             wr_sc,
    input  logic             wr_day,
    input  logic [HR_W-1:0]  hr_in,
    input  logic [MN_W-1:0]  mn_in,
    input  logic [SC_W-1:0]  sc_in,
    input  logic [DAY_W-1:0] day_in,
    output hms_t             now_hms,
    output logic [DAY_W-1:0] now_day,
    output logic             step_q
);

    localparam logic [DAY_W-1:0] DAY_MAX = {DAY_W{1'b1}};

    hms_t             hms_q;
    logic [DAY_W-1:0] day_q;
    logic             any_wr;
    logic             adv;
    logic             sc_wrap, mn_wrap, hr_wrap;

    // Purpose: decide whether this cycle applies a one-second step
    always_comb begin
        any_wr  = wr_hm | wr_sc | wr_day;
        adv     = strobe & run & ~any_wr;
        sc_wrap = (hms_q.sc >= SC_W'(SC_LAST));
        mn_wrap = (hms_q.mn >= MN_W'(MN_LAST));
        hr_wrap = (hms_q.hr >= HR_W'(HR_LAST));
    end

    // Purpose: load written fields, otherwise ripple the step through the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hms_q  <= '0;
            day_q  <= '0;
            step_q <= 1'b0;
        end else begin
            step_q <= adv;
            if (any_wr) begin
                if (wr_hm) begin
                    hms_q.hr <= hr_in;
                    hms_q.mn <= mn_in;
                end
                if (wr_sc) begin
                    hms_q.sc <= sc_in;
                end
                if (wr_day) begin
                    day_q <= day_in;
                end
            end else if (adv) begin
                if (!sc_wrap) begin
                    hms_q.sc <= hms_q.sc + 1'b1;
                end else begin
                    hms_q.sc <= '0;
                    if (!mn_wrap) begin
                        hms_q.mn <= hms_q.mn + 1'b1;
                    end else begin
                        hms_q.mn <= '0;
                        if (!hr_wrap) begin
                            hms_q.hr <= hms_q.hr + 1'b1;
                        end else begin
                            hms_q.hr <= '0;
                            day_q    <= day_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign now_hms = hms_q;
    assign now_day = day_q;

    // R3: seconds roll from 59 to 0 on a step
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hms_q.sc == SC_W'(SC_LAST)) |=> (hms_q.sc == '0));

    // R4: the full roll-over at the top of the day count returns to zero
    p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && day_q == DAY_MAX && hms_q.hr == HR_W'(HR_LAST)
         && hms_q.mn == MN_W'(MN_LAST) && hms_q.sc == SC_W'(SC_LAST))
        |=> (day_q == '0 && hms_q == '0));

    // R5: with run low and no write, the time holds
    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_wr) |=> ($stable(hms_q) && $stable(day_q)));

    // R6: a seconds write lands on that edge, even with a strobe present
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> (hms_q.sc == $past(sc_in) && !step_q));

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module rtc_alarm_cmp
// Holds the alarm day and time-of-day registers and compares them with
// the running time. hit is high whenever all four fields are equal.
// Assumes the running time comes straight from the counter registers.
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hm,
    input  logic             wr_sc,
    input  logic             wr_day,
    input  logic [HR_W-1:0]  hr_in,
    input  logic [MN_W-1:0]  mn_in,
    input  logic [SC_W-1:0]  sc_in,
    input  logic [DAY_W-1:0] day_in,
    input  hms_t             now_hms,
    input  logic [DAY_W-1:0] now_day,
    output hms_t             alm_hms,
    output logic [DAY_W-1:0] alm_day,
    output logic             hit
);

    hms_t             alm_q;
    logic [DAY_W-1:0] aday_q;

    // Purpose: capture alarm fields from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q  <= '0;
            aday_q <= '0;
        end else begin
            if (wr_hm) begin
                alm_q.hr <= hr_in;
                alm_q.mn <= mn_in;
            end
            if (wr_sc) begin
                alm_q.sc <= sc_in;
            end
            if (wr_day) begin
                aday_q <= day_in;
            end
        end
    end

    // Purpose: full-field equality between running time and alarm
    always_comb begin
        hit = (now_hms == alm_q) && (now_day == aday_q);
    end

    assign alm_hms = alm_q;
    assign alm_day = aday_q;

    // R2: an alarm seconds write is held on the next cycle
    p_alm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> (alm_q.sc == $past(sc_in)));

endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module rtc_irq_ctrl
// Latches the alarm and update events into sticky status flags that
// clear when a one is written to them, holds their enable mask and
// forms the interrupt request. Assumes the event inputs are one-cycle pulses.
module rtc_irq_ctrl
    import rtc_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr_stat,
    input  logic [NUM_EVT-1:0] clr_mask,
    input  logic               wr_en,
    input  logic [NUM_EVT-1:0] en_in,
    output logic [NUM_EVT-1:0] stat,
    output logic [NUM_EVT-1:0] en,
    output logic               irq
);

    logic [NUM_EVT-1:0] stat_q;
    logic [NUM_EVT-1:0] en_q;

    genvar g;
    generate
        for (g = 0; g < NUM_EVT; g++) begin : g_src
            // Purpose: sticky flag per source, event beats a same-cycle clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[g] <= 1'b0;
                end else if (evt[g]) begin
                    stat_q[g] <= 1'b1;
                end else if (wr_stat && clr_mask[g]) begin
                    stat_q[g] <= 1'b0;
                end
            end

            // R9: a set flag holds unless a one is written to it
            p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (stat_q[g] && !(wr_stat && clr_mask[g])) |=> stat_q[g]);

            // R9: an event always leaves its flag set
            p_event_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
                evt[g] |=> stat_q[g]);
        end
    endgenerate

    // Purpose: interrupt enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= en_in;
        end
    end

    assign stat = stat_q;
    assign en   = en_q;
    assign irq  = |(stat_q & en_q);

    // R10: with everything masked, no interrupt is raised
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

endmodule

// File: rtl/rtc_alarm_core.sv
// Module rtc_alarm_core
// Top of the real-time clock: decodes the word-wide register bus,
// holds the run bit, and connects the counter chain, the alarm compare
// and the interrupt logic. Read data is combinational on the address.
// Assumes one strobe per second and legal values in written time fields.
module rtc_alarm_core
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DAY_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned HR_MSB = HR_LSB + HR_W - 1;
    localparam int unsigned MN_MSB = MN_LSB + MN_W - 1;

    logic             run_q;
    logic             sel_thm, sel_tsc, sel_tday;
    logic             sel_ahm, sel_asc, sel_aday;
    logic             sel_ctrl, sel_stat, sel_en;
    logic [HR_W-1:0]  wr_hr;
    logic [MN_W-1:0]  wr_mn;
    logic [SC_W-1:0]  wr_sc;
    logic [DAY_W-1:0] wr_day;
    hms_t             now_hms, alm_hms;
    logic [DAY_W-1:0] now_day, alm_day;
    logic             step_q, hit;
    logic [NUM_EVT-1:0] evt, stat, en, clr_mask, en_in;
    logic             unused_wbits;

    // Purpose: address decode and write field extraction
    always_comb begin
        sel_thm  = bus_we && (bus_addr == ADDR_W'(ADR_TIME_HM));
        sel_tsc  = bus_we && (bus_addr == ADDR_W'(ADR_TIME_SEC));
        sel_tday = bus_we && (bus_addr == ADDR_W'(ADR_TIME_DAY));
        sel_ahm  = bus_we && (bus_addr == ADDR_W'(ADR_ALM_HM));
        sel_asc  = bus_we && (bus_addr == ADDR_W'(ADR_ALM_SEC));
        sel_aday = bus_we && (bus_addr == ADDR_W'(ADR_ALM_DAY));
        sel_ctrl = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
        sel_stat = bus_we && (bus_addr == ADDR_W'(ADR_STATUS));
        sel_en   = bus_we && (bus_addr == ADDR_W'(ADR_IRQ_EN));
        wr_hr    = bus_wdata[HR_MSB:HR_LSB];
        wr_mn    = bus_wdata[MN_MSB:MN_LSB];
        wr_sc    = bus_wdata[SC_W-1:0];
        wr_day   = bus_wdata[DAY_W-1:0];
        clr_mask = '0;
        en_in    = '0;
        clr_mask[EVT_ALARM] = bus_wdata[BIT_ALARM];
        clr_mask[EVT_UPD]   = bus_wdata[BIT_UPD];
        en_in[EVT_ALARM]    = bus_wdata[BIT_ALARM];
        en_in[EVT_UPD]      = bus_wdata[BIT_UPD];
    end

    assign unused_wbits = ^bus_wdata;

    // Purpose: run bit of the control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (sel_ctrl) begin
            run_q <= bus_wdata[RUN_BIT];
        end
    end

    rtc_time_chain #(.DAY_W(DAY_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .strobe  (sec_strobe),
        .wr_hm   (sel_thm),
        .wr_sc   (sel_tsc),
        .wr_day  (sel_tday),
        .hr_in   (wr_hr),
        .mn_in   (wr_mn),
        .sc_in   (wr_sc),
        .day_in  (wr_day),
        .now_hms (now_hms),
        .now_day (now_day),
        .step_q  (step_q)
    );

    rtc_alarm_cmp #(.DAY_W(DAY_W)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hm   (sel_ahm),
        .wr_sc   (sel_asc),
        .wr_day  (sel_aday),
        .hr_in   (wr_hr),
        .mn_in   (wr_mn),
        .sc_in   (wr_sc),
        .day_in  (wr_day),
        .now_hms (now_hms),
        .now_day (now_day),
        .alm_hms (alm_hms),
        .alm_day (alm_day),
        .hit     (hit)
    );

    // Purpose: event pulses, alarm only on the cycle right after a step
    always_comb begin
        evt            = '0;
        evt[EVT_ALARM] = step_q & hit;
        evt[EVT_UPD]   = step_q;
    end

    rtc_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wr_stat  (sel_stat),
        .clr_mask (clr_mask),
        .wr_en    (sel_en),
        .en_in    (en_in),
        .stat     (stat),
        .en       (en),
        .irq      (irq)
    );

    // Purpose: combinational read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_TIME_HM): begin
                bus_rdata[HR_MSB:HR_LSB] = now_hms.hr;
                bus_rdata[MN_MSB:MN_LSB] = now_hms.mn;
            end
            ADDR_W'(ADR_TIME_SEC): bus_rdata[SC_W-1:0]  = now_hms.sc;
            ADDR_W'(ADR_TIME_DAY): bus_rdata[DAY_W-1:0] = now_day;
            ADDR_W'(ADR_ALM_HM): begin
                bus_rdata[HR_MSB:HR_LSB] = alm_hms.hr;
                bus_rdata[MN_MSB:MN_LSB] = alm_hms.mn;
            end
            ADDR_W'(ADR_ALM_SEC): bus_rdata[SC_W-1:0]  = alm_hms.sc;
            ADDR_W'(ADR_ALM_DAY): bus_rdata[DAY_W-1:0] = alm_day;
            ADDR_W'(ADR_CTRL):    bus_rdata[RUN_BIT]   = run_q;
            ADDR_W'(ADR_STATUS): begin
                bus_rdata[BIT_ALARM] = stat[EVT_ALARM];
                bus_rdata[BIT_UPD]   = stat[EVT_UPD];
            end
            ADDR_W'(ADR_IRQ_EN): begin
                bus_rdata[BIT_ALARM] = en[EVT_ALARM];
                bus_rdata[BIT_UPD]   = en[EVT_UPD];
            end
            default: bus_rdata = '0;
        endcase
    end

    // R5: the run bit follows a control write on the next cycle
    p_ctrl_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |=> (run_q == $past(bus_wdata[RUN_BIT])));

    // R7: a step into the alarm time raises the alarm flag
    p_alarm_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q && hit) |=> stat[EVT_ALARM]);

    // R7: the alarm flag never rises without a step
    p_alarm_needs_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[EVT_ALARM]) |-> $past(step_q));

    // R8: every step raises the update flag
    p_update_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_q |=> stat[EVT_UPD]);

endmodule

// File: tb/rtc_alarm_core_test.sv
// Bench rtc_alarm_core_test
// Sweeps the counter chain through several thousand steps and around the
// day wrap, comparing against an arithmetic seconds-count model, and
// walks the alarm, status-clear and interrupt-mask behaviour.
module rtc_alarm_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;
    localparam int DAY_W  = 9;
    localparam int DAY_SPAN = 86400 * (1 << DAY_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sec_strobe = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_alarm_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DAY_W(DAY_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_strobe (sec_strobe),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int adr, input int data);
        @(negedge clk);
        bus_addr  = ADDR_W'(adr);
        bus_wdata = DATA_W'(data);
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int adr, output int data);
        bus_addr = ADDR_W'(adr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic tick();
        @(negedge clk);
        sec_strobe = 1'b1;
        @(negedge clk);
        sec_strobe = 1'b0;
        @(negedge clk);
    endtask

    function automatic int hm_word(input int h, input int m);
        return (h << 8) | m;
    endfunction

    task automatic load_time(input int t);
        wr(2, t / 86400);
        wr(0, hm_word((t % 86400) / 3600, (t % 3600) / 60));
        wr(1, t % 60);
    endtask

    task automatic check_time(input int t, input string tag);
        int v;
        rd(0, v);
        check(v == hm_word((t % 86400) / 3600, (t % 3600) / 60), {tag, " hour/minute"},
              v, hm_word((t % 86400) / 3600, (t % 3600) / 60));
        rd(1, v);
        check(v == t % 60, {tag, " seconds"}, v, t % 60);
        rd(2, v);
        check(v == t / 86400, {tag, " day"}, v, t / 86400);
    endtask

    initial begin
        int v;
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero after reset
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check(v == 0, "R1 reset register", v, 0);
        end
        check(irq == 1'b0, "R1 reset irq", int'(irq), 0);

        // R2: field readback, unused bits dropped
        wr(3, 16'hFFFF);
        rd(3, v);
        check(v == 16'h1F3F, "R2 alarm hour/minute fields", v, 16'h1F3F);
        wr(3, hm_word(13, 47));
        rd(3, v);
        check(v == hm_word(13, 47), "R2 alarm hour/minute readback", v, hm_word(13, 47));
        wr(4, 16'hFFFF);
        rd(4, v);
        check(v == 16'h003F, "R2 alarm seconds field", v, 16'h003F);
        wr(5, 16'hFFFF);
        rd(5, v);
        check(v == 16'h01FF, "R2 alarm day field", v, 16'h01FF);
        wr(15, 16'hFFFF);
        rd(15, v);
        check(v == 0, "R2 unmapped address", v, 0);

        // R5: control readback
        wr(6, 16'hFFFF);
        rd(6, v);
        check(v == 16'h0080, "R5 control readback", v, 16'h0080);
        // R10: only enable bits 2 and 4 exist
        wr(8, 16'hFFFF);
        rd(8, v);
        check(v == 16'h0014, "R10 enable bits", v, 16'h0014);
        wr(8, 0);

        // R5: stopped clock ignores strobes
        wr(6, 0);
        load_time(3 * 86400 + 5 * 3600 + 6 * 60 + 7);
        for (int i = 0; i < 5; i++) tick();
        check_time(3 * 86400 + 5 * 3600 + 6 * 60 + 7, "R5 stopped");
        rd(7, v);
        check(v == 0, "R5 no update flag while stopped", v, 0);

        // R3 R8 R9: sweep over 3700 steps from midnight
        wr(6, 16'h0080);
        load_time(0);
        t = 0;
        for (int i = 0; i < 3700; i++) begin
            tick();
            t = t + 1;
            check_time(t, "R3 sweep");
            rd(7, v);
            check(v == 16'h0010, "R8 update flag after step", v, 16'h0010);
            wr(7, 16'h0010);
            rd(7, v);
            check(v == 0, "R9 update flag cleared by one", v, 0);
        end

        // R3: hour and day carry sweep
        t = 86400 * 7 - 15;
        load_time(t);
        for (int i = 0; i < 30; i++) begin
            tick();
            t = t + 1;
            check_time(t, "R3 day carry");
        end

        // R4: day count wrap
        t = DAY_SPAN - 3;
        load_time(t);
        for (int i = 0; i < 6; i++) begin
            tick();
            t = (t + 1) % DAY_SPAN;
            check_time(t, "R4 day wrap");
        end

        // R6: write coincides with a strobe
        wr(7, 16'hFFFF);
        load_time(100);
        @(negedge clk);
        sec_strobe = 1'b1;
        bus_addr   = ADDR_W'(1);
        bus_wdata  = DATA_W'(30);
        bus_we     = 1'b1;
        @(negedge clk);
        sec_strobe = 1'b0;
        bus_we     = 1'b0;
        @(negedge clk);
        rd(1, v);
        check(v == 30, "R6 write wins seconds", v, 30);
        rd(0, v);
        check(v == hm_word(0, 1), "R6 no step on write", v, hm_word(0, 1));
        rd(7, v);
        check(v == 0, "R6 no update flag on write", v, 0);

        // R7 R10: alarm event and interrupt
        wr(5, 3);
        wr(3, hm_word(1, 2));
        wr(4, 5);
        load_time(3 * 86400 + 3600 + 120);
        wr(7, 16'hFFFF);
        wr(8, 16'h0004);
        for (int i = 0; i < 4; i++) tick();
        rd(7, v);
        check((v & 4) == 0, "R7 no alarm before match", v & 4, 0);
        check(irq == 1'b0, "R10 irq low before alarm", int'(irq), 0);
        tick();
        rd(7, v);
        check((v & 4) == 4, "R7 alarm flag at match", v & 4, 4);
        check(irq == 1'b1, "R10 irq on enabled alarm", int'(irq), 1);
        tick();
        rd(7, v);
        check((v & 4) == 4, "R9 alarm flag sticky", v & 4, 4);
        wr(7, 16'h0000);
        rd(7, v);
        check((v & 4) == 4, "R9 zero write no effect", v & 4, 4);
        wr(7, 16'h0004);
        rd(7, v);
        check((v & 4) == 0, "R9 alarm cleared by one", v & 4, 0);
        check(irq == 1'b0, "R10 irq low after clear", int'(irq), 0);

        // R7: writing time to the alarm value does not raise the flag
        wr(1, 5);
        repeat (2) @(negedge clk);
        rd(7, v);
        check((v & 4) == 0, "R7 write equal to alarm no flag", v & 4, 0);

        // R10: masked update event leaves irq low, unmasking raises it
        wr(7, 16'hFFFF);
        wr(8, 0);
        tick();
        rd(7, v);
        check(v == 16'h0010, "R10 masked flag set", v, 16'h0010);
        check(irq == 1'b0, "R10 masked irq", int'(irq), 0);
        wr(8, 16'h0010);
        check(irq == 1'b1, "R10 unmasked irq", int'(irq), 1);

        // R9: event and clear on the same edge, event wins
        wr(7, 16'hFFFF);
        @(negedge clk);
        sec_strobe = 1'b1;
        @(negedge clk);
        sec_strobe = 1'b0;
        bus_addr   = ADDR_W'(7);
        bus_wdata  = DATA_W'(16'h0010);
        bus_we     = 1'b1;
        @(negedge clk);
        bus_we     = 1'b0;
        rd(7, v);
        check(v == 16'h0010, "R9 event beats clear", v, 16'h0010);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule